// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the small set of control and status registers that a processor core module exposes on a 32-bit register bus. Software addresses it by word index through separate write and read ports. It returns fixed identification and status words. It holds two clock oscillator settings that a 16-bit unlock key guards. A control register lights an LED, selects whether boot flash or RAM appears at address zero, and can request a system reset.

The block also keeps an SDRAM configuration word whose reset value encodes the fitted memory size, which is given as a parameter in megabytes. It has a bus initialisation word and two flag registers, each with separate set and clear locations. A read-only window onto a 32-byte memory presence-detect table reports the same size through one of its bytes.

Read data is registered: a read request is answered on the next clock edge and the value then holds until the next request. The reset request leaves the block as a registered pulse that lasts one clock cycle.

Top module: `cmctl_top`

## Requirements
- R1: Word index 0 reads 0x411A3001, word index 4 reads 0x00100000 and word index 1 reads 0.
- R2: The lock register (index 5) keeps only bits 15:0 of a write. While it holds 0xA05F it reads as 0x0001A05F. Otherwise it reads as the stored 16-bit value, zero-extended.
- R3: Writes to the oscillator register (index 2) and the auxiliary oscillator register (index 7) take effect only while the lock register holds 0xA05F. At any other time the register keeps its value.
- R4: The control register (index 3) stores only write bits 0 and 2, and all its other bits read 0. Bit 0 drives `led_o`. Bit 2 drives `remap_o`, where 0 means boot flash is mapped at address zero and 1 means RAM is mapped there. Both outputs change on the clock edge that accepts the write.
- R5: A control write with bit 3 set makes `rst_req_o` high for exactly the one cycle after the accepting edge. Bit 3 is never stored and always reads 0.
- R6: Index 12 reads the flag word, and a write there ORs the data into it; a write to index 13 clears every flag bit that is 1 in the data. Indices 14 (read and set) and 15 (clear) do the same for a second flag word. Both flag words reset to 0.
- R7: After reset the oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, the init word (index 9) 0x00000112, and the lock, control and flag words 0. SDRAM (index 8) reads 0x00011122 ORed with a size code: 0x10 for 256 MB or more, 0x0C for 128 MB or more, 0x08 for 64 MB or more, 0x04 for 32 MB or more, and 0 below that. `led_o`, `remap_o`, `rst_req_o` and `rd_data` are 0.
- R8: The SDRAM word (index 8) and the init word (index 9) take any 32-bit write in full.
- R9: Word indices 64 to 95 read entry (index - 64) of the presence-detect table, zero-extended to 32 bits; entries 0, 1 and 2 are 0x80, 0x08 and 0x04. Indices 96 to 127 read 0.
- R10: Presence-detect entry 31 encodes the size: 64 for 256 MB or more, 32 for 128 MB or more, 16 for 64 MB or more, 4 for 32 MB or more, and 2 below that.
- R11: The voltage control indices 32 to 35, and every index not named above, read 0. A write to any of them changes no register and no output.
- R12: `rd_data` takes the addressed value on the clock edge that samples `rd_en` high and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_idx | input | IDX_W | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Word index of the read |
| rd_data | output | 32 | Registered read data |
| led_o | output | 1 | LED drive, control bit 0 |
| remap_o | output | 1 | Address-zero select: 0 boot flash, 1 RAM |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Register contents become visible on the edge that accepts a write. A read is answered on the edge that samples `rd_en`, so the bench takes `rd_data` at the falling edge after that one. `led_o` and `remap_o` are taken at the falling edge right after the write edge, and `rst_req_o` is checked high at that same falling edge and low one full cycle later. All stimulus changes on falling edges, so every sample falls half a period away from the edge that produced it, and a bench model updated at each write supplies the expected value for every read.

// File: rtl/cmctl_pkg.sv
package cmctl_pkg;

  localparam int unsigned DATA_W = 32;

  // word indices decoded by the block
  localparam int unsigned IX_ID      = 0;
  localparam int unsigned IX_PROC    = 1;
  localparam int unsigned IX_OSC     = 2;
  localparam int unsigned IX_CTRL    = 3;
  localparam int unsigned IX_STAT    = 4;
  localparam int unsigned IX_LOCK    = 5;
  localparam int unsigned IX_AUX     = 7;
  localparam int unsigned IX_SDRAM   = 8;
  localparam int unsigned IX_INIT    = 9;
  localparam int unsigned IX_FLG_SET = 12;
  localparam int unsigned IX_FLG_CLR = 13;
  localparam int unsigned IX_NV_SET  = 14;
  localparam int unsigned IX_NV_CLR  = 15;
  localparam int unsigned IX_SPD_LO  = 64;
  localparam int unsigned SPD_N      = 32;

  // control bit positions
  localparam int unsigned CB_LED   = 0;
  localparam int unsigned CB_REMAP = 2;
  localparam int unsigned CB_RESET = 3;

  localparam logic [DATA_W-1:0] ID_WORD    = 32'h411A_3001;
  localparam logic [DATA_W-1:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [15:0]       UNLOCK_KEY = 16'hA05F;
  localparam logic [DATA_W-1:0] OSC_RST    = 32'h0100_0048;
  localparam logic [DATA_W-1:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [DATA_W-1:0] INIT_RST   = 32'h0000_0112;
  localparam logic [DATA_W-1:0] SDRAM_BASE = 32'h0001_1122;

  typedef struct packed {
    logic osc;
    logic ctrl;
    logic lock;
    logic aux;
    logic sdram;
    logic init;
    logic flg_set;
    logic flg_clr;
    logic nv_set;
    logic nv_clr;
  } cm_wsel_t;

  typedef enum logic [3:0] {
    RS_ZERO, RS_ID, RS_OSC, RS_CTRL, RS_STAT, RS_LOCK, RS_AUX,
    RS_SDRAM, RS_INIT, RS_FLAGS, RS_NV, RS_SPD
  } cm_rsel_t;

  function automatic logic [DATA_W-1:0] sdram_size_code(int unsigned mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] spd_size_byte(int unsigned mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] spd_entry(logic [4:0] k, int unsigned mb);
    logic [7:0] v;
    case (k)
      5'd0:  v = 8'h80;
      5'd1:  v = 8'h08;
      5'd2:  v = 8'h04;
      5'd3:  v = 8'h0B;
      5'd4:  v = 8'h09;
      5'd5:  v = 8'h01;
      5'd6:  v = 8'h40;
      5'd8:  v = 8'h02;
      5'd9:  v = 8'hA0;
      5'd10: v = 8'hA0;
      5'd13: v = 8'h08;
      5'd15: v = 8'h01;
      5'd16: v = 8'h0E;
      5'd17: v = 8'h04;
      5'd18: v = 8'h1C;
      5'd19: v = 8'h01;
      5'd20: v = 8'h02;
      5'd21: v = 8'h20;
      5'd22: v = 8'hC0;
      5'd27: v = 8'h30;
      5'd28: v = 8'h28;
      5'd29: v = 8'h30;
      5'd30: v = 8'h28;
      5'd31: v = spd_size_byte(mb);
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cmctl_decode.sv
module cmctl_decode
  import cmctl_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output cm_wsel_t         wsel,
  output cm_rsel_t         rsel
);

  localparam int unsigned SPD_HI = IX_SPD_LO + SPD_N - 1;

  int unsigned wi;
  int unsigned ri;

  // write strobes: at most one per cycle
  always_comb begin
    wi   = 32'(wr_idx);
    wsel = '0;
    if (wr_en) begin
      case (wi)
        IX_OSC:     wsel.osc     = 1'b1;
        IX_CTRL:    wsel.ctrl    = 1'b1;
        IX_LOCK:    wsel.lock    = 1'b1;
        IX_AUX:     wsel.aux     = 1'b1;
        IX_SDRAM:   wsel.sdram   = 1'b1;
        IX_INIT:    wsel.init    = 1'b1;
        IX_FLG_SET: wsel.flg_set = 1'b1;
        IX_FLG_CLR: wsel.flg_clr = 1'b1;
        IX_NV_SET:  wsel.nv_set  = 1'b1;
        IX_NV_CLR:  wsel.nv_clr  = 1'b1;
        default:    wsel         = '0;
      endcase
    end
  end

  // read source select
  always_comb begin
    ri = 32'(rd_idx);
    case (ri)
      IX_ID:      rsel = RS_ID;
      IX_OSC:     rsel = RS_OSC;
      IX_CTRL:    rsel = RS_CTRL;
      IX_STAT:    rsel = RS_STAT;
      IX_LOCK:    rsel = RS_LOCK;
      IX_AUX:     rsel = RS_AUX;
      IX_SDRAM:   rsel = RS_SDRAM;
      IX_INIT:    rsel = RS_INIT;
      IX_FLG_SET: rsel = RS_FLAGS;
      IX_NV_SET:  rsel = RS_NV;
      default:    rsel = (ri >= IX_SPD_LO && ri <= SPD_HI) ? RS_SPD : RS_ZERO;
    endcase
  end

  // R11: a write reaches at most one register
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));

  // R11: an unlisted write index raises no strobe
  p_unlisted_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_idx) >= 32'd32) && (32'(wr_idx) <= 32'd35)) |-> (wsel == '0));

endmodule

// File: rtl/cmctl_setclr.sv
module cmctl_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = set_en | clr_en;
    q_d  = q;
    if (set_en)      q_d = q | din;
    else if (clr_en) q_d = q & ~din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  // R6: set write leaves every data bit set
  p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(din)) == $past(din)));

  // R6: clear write leaves every data bit clear
  p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(din)) == '0));

  // R6: bits outside the data keep their value
  p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> ((q & ~$past(din)) == ($past(q) & ~$past(din))));

endmodule

// File: rtl/cmctl_spd.sv
module cmctl_spd
  import cmctl_pkg::*;
#(
  parameter int unsigned MEM_MB = 128
) (
  input  logic [4:0]        entry,
  output logic [DATA_W-1:0] value
);

  always_comb begin
    value = {{(DATA_W-8){1'b0}}, spd_entry(entry, MEM_MB)};
  end

endmodule

// File: rtl/cmctl_top.sv
module cmctl_top
  import cmctl_pkg::*;
#(
  parameter int unsigned MEM_MB = 128,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  output logic              led_o,
  output logic              remap_o,
  output logic              rst_req_o
);

  localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);
  localparam int unsigned       N_BANK    = 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  cm_wsel_t wsel;
  cm_rsel_t rsel;

  cmctl_decode #(.IDX_W(IDX_W)) u_decode (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .wsel   (wsel),
    .rsel   (rsel)
  );

  // ---------------- plain registers ----------------
  logic [DATA_W-1:0] osc_q, osc_d;
  logic [DATA_W-1:0] aux_q, aux_d;
  logic [DATA_W-1:0] sdram_q, sdram_d;
  logic [DATA_W-1:0] init_q, init_d;
  logic [15:0]       lock_q, lock_d;
  logic              led_q, led_d;
  logic              remap_q, remap_d;
  logic              rreq_q, rreq_d;
  logic              unlocked;
  logic              osc_en, aux_en, ctrl_en;

  always_comb begin
    unlocked = (lock_q == UNLOCK_KEY);
    osc_en   = wsel.osc & unlocked;
    aux_en   = wsel.aux & unlocked;
    ctrl_en  = wsel.ctrl;
    osc_d    = wr_data;
    aux_d    = wr_data;
    sdram_d  = wr_data;
    init_d   = wr_data;
    lock_d   = wr_data[15:0];
    led_d    = wr_data[CB_LED];
    remap_d  = wr_data[CB_REMAP];
    rreq_d   = wsel.ctrl & wr_data[CB_RESET];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      osc_q   <= OSC_RST;
      aux_q   <= AUX_RST;
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_RST;
      lock_q  <= '0;
      led_q   <= 1'b0;
      remap_q <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (osc_en)     osc_q   <= osc_d;
      if (aux_en)     aux_q   <= aux_d;
      if (wsel.sdram) sdram_q <= sdram_d;
      if (wsel.init)  init_q  <= init_d;
      if (wsel.lock)  lock_q  <= lock_d;
      if (ctrl_en) begin
        led_q   <= led_d;
        remap_q <= remap_d;
      end
      rreq_q <= rreq_d;
    end
  end

  // ---------------- flag banks ----------------
  logic [N_BANK-1:0]              set_v, clr_v;
  logic [N_BANK-1:0][DATA_W-1:0]  bank_q;

  assign set_v = {wsel.nv_set, wsel.flg_set};
  assign clr_v = {wsel.nv_clr, wsel.flg_clr};

  for (genvar g = 0; g < N_BANK; g++) begin : g_flagbank
    cmctl_setclr #(.W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_q),
      .set_en (set_v[g]),
      .clr_en (clr_v[g]),
      .din    (wr_data),
      .q      (bank_q[g])
    );
  end

  // ---------------- presence-detect window ----------------
  logic [DATA_W-1:0] spd_val;

  cmctl_spd #(.MEM_MB(MEM_MB)) u_spd (
    .entry (rd_idx[4:0]),
    .value (spd_val)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    case (rsel)
      RS_ID:    rd_d = ID_WORD;
      RS_OSC:   rd_d = osc_q;
      RS_CTRL:  rd_d = {{(DATA_W-3){1'b0}}, remap_q, 1'b0, led_q};
      RS_STAT:  rd_d = STAT_WORD;
      RS_LOCK:  rd_d = {{(DATA_W-17){1'b0}}, unlocked, lock_q};
      RS_AUX:   rd_d = aux_q;
      RS_SDRAM: rd_d = sdram_q;
      RS_INIT:  rd_d = init_q;
      RS_FLAGS: rd_d = bank_q[0];
      RS_NV:    rd_d = bank_q[1];
      RS_SPD:   rd_d = spd_val;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data   = rd_q;
  assign led_o     = led_q;
  assign remap_o   = remap_q;
  assign rst_req_o = rreq_q;

  // ---------------- assertions ----------------
  // R3: a write while locked leaves the oscillator unchanged
  p_osc_locked_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && (wr_idx == IDX_W'(IX_OSC)) && (lock_q != UNLOCK_KEY)) |=> $stable(osc_q));

  // R3: same for the auxiliary oscillator
  p_aux_locked_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && (wr_idx == IDX_W'(IX_AUX)) && (lock_q != UNLOCK_KEY)) |=> $stable(aux_q));

  // R4: control write sets the remap and LED outputs
  p_ctrl_outputs_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && (wr_idx == IDX_W'(IX_CTRL))) |=>
      ((remap_o == $past(wr_data[CB_REMAP])) && (led_o == $past(wr_data[CB_LED]))));

  // R5: reset request follows a control write with bit 3
  p_rreq_raise_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && (wr_idx == IDX_W'(IX_CTRL)) && wr_data[CB_RESET]) |=> rst_req_o);

  // R5: no request without such a write
  p_rreq_only_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr_en && (wr_idx == IDX_W'(IX_CTRL)) && wr_data[CB_RESET]) |=> !rst_req_o);

  // R2: unlocked key reads with the extra flag bit
  p_lock_read_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && (rd_idx == IDX_W'(IX_LOCK)) && (lock_q == UNLOCK_KEY)) |=> (rd_data == 32'h0001_A05F));

  // R11: voltage indices read zero
  p_volt_zero_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && (32'(rd_idx) >= 32'd32) && (32'(rd_idx) <= 32'd35)) |=> (rd_data == '0));

  // R12: read data holds without a read request
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/test_cmctl_top.sv
module test_cmctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_MB     = 128;
  localparam int IDX_W      = 7;
  localparam logic [15:0] KEY = 16'hA05F;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_data;
  logic             rd_en;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      rd_data;
  logic             led_o;
  logic             remap_o;
  logic             rst_req_o;

  cmctl_top #(.MEM_MB(MEM_MB), .IDX_W(IDX_W)) i_cmctl_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .led_o(led_o), .remap_o(remap_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk;
  int n_bad;

  // bench model
  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nv;
  logic [15:0] m_lock;
  logic [2:0]  m_ctrl;

  function automatic logic [31:0] size_code(int mb);
    if (mb >= 256) return 32'h10;
    if (mb >= 128) return 32'h0C;
    if (mb >= 64)  return 32'h08;
    if (mb >= 32)  return 32'h04;
    return 32'h0;
  endfunction

  function automatic logic [31:0] spd_last(int mb);
    if (mb >= 256) return 32'd64;
    if (mb >= 128) return 32'd32;
    if (mb >= 64)  return 32'd16;
    if (mb >= 32)  return 32'd4;
    return 32'd2;
  endfunction

  function automatic logic [31:0] exp_read(int idx);
    case (idx)
      0:  return 32'h411A_3001;
      2:  return m_osc;
      3:  return {29'd0, m_ctrl[2], 1'b0, m_ctrl[0]};
      4:  return 32'h0010_0000;
      5:  return (m_lock == KEY) ? 32'h0001_A05F : {16'd0, m_lock};
      7:  return m_aux;
      8:  return m_sdram;
      9:  return m_init;
      12: return m_flg;
      14: return m_nv;
      64: return 32'h80;
      65: return 32'h08;
      66: return 32'h04;
      95: return spd_last(MEM_MB);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(int idx, logic [31:0] d);
    case (idx)
      2:  if (m_lock == KEY) m_osc = d;
      3:  m_ctrl = {d[2], 1'b0, d[0]};
      5:  m_lock = d[15:0];
      7:  if (m_lock == KEY) m_aux = d;
      8:  m_sdram = d;
      9:  m_init = d;
      12: m_flg = m_flg | d;
      13: m_flg = m_flg & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_wr(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(idx, d);
  endtask

  task automatic do_rd(int idx, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = IDX_W'(idx);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(string tag, int idx);
    logic [31:0] v;
    do_rd(idx, v);
    check(tag, v, exp_read(idx));
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  localparam int NIX = 24;
  int ixl [NIX] = '{0, 1, 2, 3, 4, 5, 7, 8, 9, 12, 13, 14, 15, 32, 33, 35,
                    20, 6, 64, 65, 66, 95, 96, 127};

  initial begin
    logic [31:0] v;
    n_chk = 0; n_bad = 0;
    wr_en = 0; rd_en = 0; wr_idx = '0; rd_idx = '0; wr_data = '0;
    m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF; m_init = 32'h0000_0112;
    m_sdram = 32'h0001_1122 | size_code(MEM_MB);
    m_flg = 0; m_nv = 0; m_lock = 0; m_ctrl = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state R7
    check("R7 led", {31'd0, led_o}, 0);
    check("R7 remap", {31'd0, remap_o}, 0);
    check("R7 rst_req", {31'd0, rst_req_o}, 0);
    check("R7 rd_data", rd_data, 0);
    rd_chk("R7 osc", 2);
    rd_chk("R7 aux", 7);
    rd_chk("R7 init", 9);
    rd_chk("R7 sdram", 8);
    do_rd(8, v); check("R7 sdram size", v, 32'h0001_112E);
    rd_chk("R7 lock", 5);
    rd_chk("R7 flags", 12);

    // R1
    do_rd(0, v); check("R1 id", v, 32'h411A_3001);
    do_rd(4, v); check("R1 stat", v, 32'h0010_0000);
    do_rd(1, v); check("R1 proc", v, 0);

    // R3 locked write ignored
    do_wr(2, 32'hDEAD_BEEF);
    do_rd(2, v); check("R3 osc locked", v, 32'h0100_0048);
    // R2
    do_wr(5, 32'h1234_A05F);
    do_rd(5, v); check("R2 key read", v, 32'h0001_A05F);
    do_wr(2, 32'hDEAD_BEEF);
    do_rd(2, v); check("R3 osc unlocked", v, 32'hDEAD_BEEF);
    do_wr(7, 32'h0BAD_F00D);
    do_rd(7, v); check("R3 aux unlocked", v, 32'h0BAD_F00D);
    do_wr(5, 32'hFFFF_0001);
    do_rd(5, v); check("R2 low half", v, 32'h0000_0001);
    do_wr(7, 32'h1111_1111);
    do_rd(7, v); check("R3 aux locked", v, 32'h0BAD_F00D);

    // R4 R5
    do_wr(3, 32'hFFFF_FFFF);
    check("R5 pulse high", {31'd0, rst_req_o}, 1);
    check("R4 led", {31'd0, led_o}, 1);
    check("R4 remap", {31'd0, remap_o}, 1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, rst_req_o}, 0);
    do_rd(3, v); check("R5 ctrl readback", v, 32'h5);
    do_wr(3, 32'h0000_0008);
    check("R5 pulse only", {31'd0, rst_req_o}, 1);
    check("R4 remap cleared", {31'd0, remap_o}, 0);
    check("R4 led cleared", {31'd0, led_o}, 0);

    // R6
    do_wr(12, 32'h0000_00F0);
    do_wr(12, 32'h0000_0F00);
    do_rd(12, v); check("R6 flags or", v, 32'h0000_0FF0);
    do_wr(13, 32'h0000_0330);
    do_rd(12, v); check("R6 flags clr", v, 32'h0000_0CC0);
    do_wr(14, 32'h8000_0001);
    do_wr(15, 32'h0000_0001);
    do_rd(14, v); check("R6 nv", v, 32'h8000_0000);
    do_rd(12, v); check("R6 banks separate", v, 32'h0000_0CC0);

    // R8
    do_wr(8, 32'hA5A5_5A5A);
    do_rd(8, v); check("R8 sdram", v, 32'hA5A5_5A5A);
    do_wr(9, 32'h0F0F_F0F0);
    do_rd(9, v); check("R8 init", v, 32'h0F0F_F0F0);

    // R9 R10
    do_rd(64, v); check("R9 spd0", v, 32'h80);
    do_rd(65, v); check("R9 spd1", v, 32'h08);
    do_rd(66, v); check("R9 spd2", v, 32'h04);
    do_rd(96, v); check("R9 upper zero", v, 0);
    do_rd(127, v); check("R9 top zero", v, 0);
    do_rd(95, v); check("R10 size byte", v, spd_last(MEM_MB));

    // R11
    do_wr(33, 32'hFFFF_FFFF);
    check("R11 no pulse", {31'd0, rst_req_o}, 0);
    do_rd(33, v); check("R11 voltage", v, 0);
    do_wr(20, 32'hFFFF_FFFF);
    do_rd(20, v); check("R11 unlisted", v, 0);
    rd_chk("R11 osc kept", 2);
    rd_chk("R11 flags kept", 12);
    rd_chk("R11 ctrl kept", 3);

    // R12
    do_rd(0, v);
    @(negedge clk); rd_idx = IDX_W'(2);
    repeat (3) @(negedge clk);
    check("R12 hold", rd_data, 32'h411A_3001);

    // random phase
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      int wi;
      int ri;
      logic [31:0] d;
      wi = ixl[$urandom_range(NIX-1, 0)];
      ri = ixl[$urandom_range(NIX-1, 0)];
      d  = $urandom;
      if (wi == 5 && $urandom_range(1, 0) == 1) d[15:0] = KEY;
      do_wr(wi, d);
      check("R5 random pulse", {31'd0, rst_req_o}, {31'd0, (wi == 3) && d[3]});
      check("R4 random led", {31'd0, led_o}, {31'd0, m_ctrl[0]});
      check("R4 random remap", {31'd0, remap_o}, {31'd0, m_ctrl[2]});
      rd_chk("R2 R3 R6 R11 random read", ri);
    end

    report();
    $finish;
  end

endmodule